// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight status flags of an I2C controller and presents them to software as one byte. The bus engine supplies one-cycle event pulses. These include a start generated by this controller, a stop seen on the bus, a lost arbitration, and one event for each of the remaining flags. The control side supplies the enable bit, an exit-communication pulse, a one-cycle CPU read strobe and a pulse that marks a single-bit write aimed at some other register.

Two flags carry behaviour of their own. The master flag follows this controller's ownership of the bus. The arbitration-lost flag records a lost arbitration and clears itself once software has read the byte. The other six flags are sticky: an event sets them, and only the global clears reset them. The global clears are a falling edge of the enable bit, the single-bit write aimed at another register, and reset.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset, status_o reads 0x00. Bit 7 is master, bit 6 is arbitration-lost, bit 5 is extension-code, bit 4 is address-match, bit 3 is transmit, bit 2 is ack-detected, bit 1 is start-detected and bit 0 is stop-detected.
- R2: A start_gen_i pulse sets status bit 7 at the next clock edge.
- R3: A stop_det_i, arb_lost_i or exit_comm_i pulse clears bit 7 at the next edge. When any of them arrives in the same cycle as start_gen_i, the clear wins.
- R4: An arb_lost_i pulse sets bit 6 and clears bit 7 at the same edge.
- R5: A rd_i pulse clears bit 6 at the next edge. In the cycle of the strobe, rd_data_o still shows the byte from before the clear.
- R6: When arb_lost_i and rd_i arrive in the same cycle, bit 6 is set after the edge.
- R7: A 1-to-0 change of en_i clears all eight bits at that edge. A rising en_i, or en_i held low, clears nothing.
- R8: A wr_other_bit_i pulse clears all eight bits at the next edge.
- R9: Each of ext_code_i, addr_match_i, xmit_i, ack_det_i, start_det_i and stop_det_i sets its own bit (5 down to 0). The bit holds until a global clear.
- R10: arb_clr_o is high for exactly the one cycle after a read strobe that cleared a set bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable bit |
| exit_comm_i | input | 1 | Exit-communication command pulse |
| rd_i | input | 1 | CPU read strobe, one cycle wide |
| wr_other_bit_i | input | 1 | Single-bit write aimed at another register |
| start_gen_i | input | 1 | This controller generated a start |
| stop_det_i | input | 1 | Stop condition detected |
| arb_lost_i | input | 1 | Arbitration lost |
| ext_code_i | input | 1 | Extension code received |
| addr_match_i | input | 1 | Own address matched |
| xmit_i | input | 1 | Transmit mode entered |
| ack_det_i | input | 1 | Acknowledge detected |
| start_det_i | input | 1 | Start condition detected |
| status_o | output | 8 | Status byte |
| rd_data_o | output | 8 | Read data, the byte before any clear-on-read |
| arb_clr_o | output | 1 | Arbitration-lost flag was cleared by a read |

## Verification
The bench drives several coincidences that a careless design resolves the wrong way. One is a start and a stop in the same cycle: a set-priority design would leave the master bit high. Another is a lost arbitration that lands on a read strobe: a read-priority design would drop the event. The bench also checks the read data during the strobe, where a design that clears before the read returns 0 in bit 6. Finally it holds the enable bit low and raises it again without any clear, so a design that clears on the level of the enable bit, or on its rising edge, wipes the flags at the wrong time.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W     = 8;
  localparam int NUM_STICKY = 6;
  localparam int MS_BIT     = 7;
  localparam int ALD_BIT    = 6;
  // sticky flags occupy bits NUM_STICKY-1 downto 0
endpackage

// File: rtl/i2c_stat_fall.sv
module i2c_stat_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag #(
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hard_clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (SET_WINS) begin : g_set_pri
      always_comb begin
        if (hard_clr_i) q_d = 1'b0;
        else if (set_i) q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
        else            q_d = q_o;
      end
    end else begin : g_clr_pri
      always_comb begin
        if (hard_clr_i || clr_i) q_d = 1'b0;
        else if (set_i)          q_d = 1'b1;
        else                     q_d = q_o;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              exit_comm_i,
  input  logic              rd_i,
  input  logic              wr_other_bit_i,
  input  logic              start_gen_i,
  input  logic              stop_det_i,
  input  logic              arb_lost_i,
  input  logic              ext_code_i,
  input  logic              addr_match_i,
  input  logic              xmit_i,
  input  logic              ack_det_i,
  input  logic              start_det_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              arb_clr_o
);
  logic                  en_fall;
  logic                  glob_clr;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_q;
  logic                  ms_q;
  logic                  ald_q;

  i2c_stat_fall u_en_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (en_i),
    .fall_o(en_fall)
  );

  assign glob_clr = en_fall | wr_other_bit_i;

  i2c_stat_flag #(.SET_WINS(1'b0)) u_ms (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (start_gen_i),
    .clr_i     (stop_det_i | arb_lost_i | exit_comm_i),
    .hard_clr_i(glob_clr),
    .q_o       (ms_q)
  );

  // new loss event beats the read so it is never dropped
  i2c_stat_flag #(.SET_WINS(1'b1)) u_ald (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (arb_lost_i),
    .clr_i     (rd_i),
    .hard_clr_i(glob_clr),
    .q_o       (ald_q)
  );

  assign sticky_set = {ext_code_i, addr_match_i, xmit_i, ack_det_i, start_det_i, stop_det_i};

  generate
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
      i2c_stat_flag #(.SET_WINS(1'b0)) u_flag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (sticky_set[i]),
        .clr_i     (1'b0),
        .hard_clr_i(glob_clr),
        .q_o       (sticky_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arb_clr_o <= 1'b0;
    else         arb_clr_o <= rd_i & ald_q & ~arb_lost_i;
  end

  assign status_o  = {ms_q, ald_q, sticky_q};
  assign rd_data_o = status_o;
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk
  import i2c_stat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              exit_comm_i,
  input logic              rd_i,
  input logic              wr_other_bit_i,
  input logic              start_gen_i,
  input logic              stop_det_i,
  input logic              arb_lost_i,
  input logic              ext_code_i,
  input logic              addr_match_i,
  input logic              xmit_i,
  input logic              ack_det_i,
  input logic              start_det_i,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] rd_data_o,
  input logic              arb_clr_o
);
  a_r2_ms_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_gen_i && en_i && !wr_other_bit_i && !stop_det_i && !arb_lost_i && !exit_comm_i
    |=> status_o[MS_BIT]);

  a_r3_ms_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i || arb_lost_i || exit_comm_i |=> !status_o[MS_BIT]);

  a_r4_arb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i && en_i && !wr_other_bit_i |=> status_o[ALD_BIT] && !status_o[MS_BIT]);

  a_r5_rd_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !arb_lost_i |=> !status_o[ALD_BIT]);

  a_r6_arb_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && arb_lost_i && en_i && !wr_other_bit_i |=> status_o[ALD_BIT]);

  a_r7_en_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) && $past(rst_ni) |-> ##1 status_o == '0);

  a_r8_wr_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other_bit_i |=> status_o == '0);

  a_r10_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_clr_o |-> !status_o[ALD_BIT] && $past(rd_i));
endmodule

bind i2c_stat_reg i2c_stat_reg_chk chk_i (.*);

// File: tb/i2c_stat_reg_tb_top.sv
`timescale 1ns/1ps
module i2c_stat_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, ex, rd, wo;
  logic [7:0] ev; // 7 start_gen,6 arb_lost,5 ext,4 addr,3 xmit,2 ack,1 start_det,0 stop
  logic [7:0] status, rdata;
  logic arb_clr;
  int total = 0, bad = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_st;
  logic m_en;
  logic done = 1'b0;

  always #2 clk = ~clk;

  i2c_stat_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .exit_comm_i(ex), .rd_i(rd),
    .wr_other_bit_i(wo), .start_gen_i(ev[7]), .stop_det_i(ev[0]),
    .arb_lost_i(ev[6]), .ext_code_i(ev[5]), .addr_match_i(ev[4]),
    .xmit_i(ev[3]), .ack_det_i(ev[2]), .start_det_i(ev[1]),
    .status_o(status), .rd_data_o(rdata), .arb_clr_o(arb_clr)
  );

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare outputs after each edge against scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {arb_clr, status}, e);
    end
  end

  // driver: apply one cycle of stimulus, push expected result of the edge
  task automatic step(string tag, logic e_in, logic x_in, logic r_in, logic w_in, logic [7:0] v);
    logic glob, clr;
    logic [7:0] nx;
    @(negedge clk);
    en = e_in; ex = x_in; rd = r_in; wo = w_in; ev = v;
    #0.1;
    if (r_in) chk({tag, " R5 rd_data"}, {1'b0, rdata}, {1'b0, m_st});
    glob = w_in | (m_en & ~e_in);
    nx = m_st;
    if (glob || v[0] || v[6] || x_in) nx[7] = 1'b0;
    else if (v[7]) nx[7] = 1'b1;
    if (glob) nx[6] = 1'b0;
    else if (v[6]) nx[6] = 1'b1;
    else if (r_in) nx[6] = 1'b0;
    for (int i = 0; i < 6; i++) nx[i] = glob ? 1'b0 : (v[i] ? 1'b1 : m_st[i]);
    clr = r_in & m_st[6] & ~v[6];
    exp_q.push_back({clr, nx});
    tag_q.push_back(tag);
    m_st = nx;
    m_en = e_in;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    en = 0; ex = 0; rd = 0; wo = 0; ev = '0;
    m_st = '0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1 reset", {arb_clr, status}, 9'h000);
    step("R7 rise no clear", 1, 0, 0, 0, 8'h00);
    step("R2 start", 1, 0, 0, 0, 8'h80);
    step("R9 sticky", 1, 0, 0, 0, 8'h3E);
    step("R9 hold", 1, 0, 0, 0, 8'h00);
    step("R3 stop+start", 1, 0, 0, 0, 8'h81);
    step("R2 start again", 1, 0, 0, 0, 8'h80);
    step("R3 exit", 1, 1, 0, 0, 8'h00);
    step("R2 start", 1, 0, 0, 0, 8'h80);
    step("R4 arb lost", 1, 0, 0, 0, 8'h40);
    step("R5 read clears", 1, 0, 1, 0, 8'h00);
    step("R10 pulse end", 1, 0, 0, 0, 8'h00);
    step("R4 arb lost", 1, 0, 0, 0, 8'h40);
    step("R6 arb+read", 1, 0, 1, 0, 8'h40);
    step("R5 read clears", 1, 0, 1, 0, 8'h00);
    step("R5 read empty", 1, 0, 1, 0, 8'h00);
    step("R2 start", 1, 0, 0, 0, 8'hA4);
    step("R8 write other", 1, 0, 0, 0, 8'h00);
    step("R8 clear", 1, 0, 0, 1, 8'h00);
    step("R9 sticky", 1, 0, 0, 0, 8'hBF);
    step("R7 fall clears", 0, 0, 0, 0, 8'h00);
    step("R7 low set", 0, 0, 0, 0, 8'h12);
    step("R7 low hold", 0, 0, 0, 0, 8'h00);
    step("R7 rise hold", 1, 0, 0, 0, 8'h00);
    step("R3 arb+start", 1, 0, 0, 0, 8'hC0);
    step("R7 fall", 0, 0, 0, 0, 8'h00);
    step("idle", 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule